// File: doc/BRIEF.md
# Serial Filter Configuration Register Bank

This block receives a three-wire serial stream (clock, data, active-high enable) and loads three write-only configuration registers for a programmable filter. While the enable is high, each rising edge of the serial clock shifts one data bit into an 8-bit frame register, most significant bit first. When the enable drops, a complete frame is decoded. Its two leading bits pick the target register and its six trailing bits become that register's contents.

All three serial wires pass through two-flop synchronizers into the system clock domain, and their edges are found there. A receive state machine has three states. `ST_IDLE` waits for the enable. `ST_SHIFT` collects bits. `ST_COMMIT` is a single-cycle write strobe. The transitions are: `ST_IDLE -> ST_SHIFT` when the enable is seen high. `ST_SHIFT -> ST_COMMIT` when the enable falls after eight or more bits. `ST_SHIFT -> ST_IDLE` when the enable falls after fewer bits, which discards the frame. `ST_COMMIT -> ST_IDLE`, or `ST_COMMIT -> ST_SHIFT` if the enable is already high again.

The registers themselves have no reset. Software clears them by writing zero frames. Valid flags, which are cleared by the system reset, record which registers have been written. A ready output rises once all three registers hold written data.

Top module: `serial_cfg_bank`

## Requirements
- R1: A data bit is shifted in only on a rising serial clock edge while the enable is high. Clock edges seen with the enable low add no bits.
- R2: A frame is applied when the enable falls. If more than 8 bits were shifted in, the last 8 bits are used, with the earliest of those 8 taken as D7. Outputs stay unchanged between frames.
- R3: A frame of fewer than 8 bits is discarded and changes no output or flag.
- R4: Address D7..D6 = 00 writes register A. D2..D0 drive `octave_code`, and D5..D3 drive `freq_step[2:0]`.
- R5: Address 01 writes register B. D5 drives `osc_test`, D4 is ignored, and D3..D0 drive `freq_step[6:3]`.
- R6: Address 11 writes the gain register. `gain_code` shows D5..D0. For codes 0 to 41, `gain_half_db` equals the code. An all-zero payload clears the addressed register.
- R7: For gain codes above 41, `gain_half_db` reads 41, while `gain_code` keeps the raw value.
- R8: A frame with address 10 changes no output and no flag.
- R9: After reset, `slot_valid` (bit 0 = A, bit 1 = B, bit 2 = gain) and `cfg_ready` read 0. Each valid bit sets on the first write to its register and never clears. `cfg_ready` is high only when all three bits are set.
- R10: Frames are received correctly with a serial clock period of 4 system clocks (2 high, 2 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for synchronizers, state machine and valid flags |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Serial enable, active high |
| octave_code | output | 3 | Frequency octave code from register A |
| freq_step | output | 7 | Frequency step: B[3:0] above A[5:3] |
| osc_test | output | 1 | Oscillator test enable from register B |
| gain_code | output | 6 | Raw gain code |
| gain_half_db | output | 6 | Gain in half-dB units, clamped to 41 |
| slot_valid | output | 3 | Per-register written flags |
| cfg_ready | output | 1 | All three registers have been written |

## Verification
The frame decoder is driven with one frame for each legal address. Each of these frames has distinct payload bits, so a swapped or shifted field shows up as a wrong value. The frame for address 10 shows whether the decoder rejects that code instead of aliasing it onto a live register. Frames of 5 and 10 bits separate the rule for a short frame (discard) from the rule for a long frame (keep the last eight). Clock pulses sent while the enable is low show whether shifting is gated by the enable. Gain codes 20, 41, 42 and 63 probe both sides of the clamp. The fast-clock frame and the all-zero clearing frames, sent at the minimum serial clock period, confirm that the synchronizer and edge detector keep up.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } rx_state_e;

    localparam logic [1:0] ADDR_FREQ_A = 2'b00;
    localparam logic [1:0] ADDR_FREQ_B = 2'b01;
    localparam logic [1:0] ADDR_GAIN   = 2'b11;

    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) stage_q[s] <= async_in;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfgbank_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               sen_s,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               commit
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    rx_state_e state_q, state_d;
    logic      sclk_d, sen_d;
    logic      sclk_rise, en_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sen_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sen_d  <= sen_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign en_fall   = ~sen_s & sen_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sen_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (en_fall) state_d = (bit_cnt == FULL_CNT) ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                state_d = sen_s ? ST_SHIFT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame   <= '0;
            bit_cnt <= '0;
        end else if (state_q != ST_SHIFT) begin
            bit_cnt <= '0;
        end else if (sclk_rise && sen_s) begin
            frame   <= {frame[FRAME_W-2:0], sdat_s};
            bit_cnt <= (bit_cnt == FULL_CNT) ? FULL_CNT : bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        commit = (state_q == ST_COMMIT);
    end

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfgbank_pkg::*;
#(
    parameter int FRAME_W  = 8,
    parameter int GAIN_MAX = 41,
    localparam int PAY_W   = FRAME_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [FRAME_W-1:0]   frame,
    output logic [2:0]           octave_code,
    output logic [6:0]           freq_step,
    output logic                 osc_test,
    output logic [PAY_W-1:0]     gain_code,
    output logic [PAY_W-1:0]     gain_half_db,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 cfg_ready
);

    localparam logic [PAY_W-1:0] GAIN_CEIL = PAY_W'(GAIN_MAX);

    logic [1:0]       addr;
    logic [PAY_W-1:0] payload;
    logic [5:0]       reg_a;
    logic [4:0]       reg_b;
    logic [PAY_W-1:0] reg_g;
    logic [NUM_SLOTS-1:0] hit;

    assign addr    = frame[FRAME_W-1 -: 2];
    assign payload = frame[PAY_W-1:0];

    assign hit[0] = wr_en && (addr == ADDR_FREQ_A);
    assign hit[1] = wr_en && (addr == ADDR_FREQ_B);
    assign hit[2] = wr_en && (addr == ADDR_GAIN);

    // configuration storage: no reset, cleared by software frames
    always_ff @(posedge clk) begin
        if (hit[0]) reg_a <= payload[5:0];
        if (hit[1]) reg_b <= {payload[5], payload[3:0]};
        if (hit[2]) reg_g <= payload;
    end

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_valid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      slot_valid[i] <= 1'b0;
                else if (hit[i]) slot_valid[i] <= 1'b1;
            end
        end
    endgenerate

    assign octave_code  = reg_a[2:0];
    assign freq_step    = {reg_b[3:0], reg_a[5:3]};
    assign osc_test     = reg_b[4];
    assign gain_code    = reg_g;
    assign gain_half_db = (reg_g > GAIN_CEIL) ? GAIN_CEIL : reg_g;
    assign cfg_ready    = &slot_valid;

endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int GAIN_MAX    = 41,
    parameter int SYNC_STAGES = 2,
    localparam int PAY_W      = FRAME_W - 2,
    localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_en,
    output logic [2:0]           octave_code,
    output logic [6:0]           freq_step,
    output logic                 osc_test,
    output logic [PAY_W-1:0]     gain_code,
    output logic [PAY_W-1:0]     gain_half_db,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 cfg_ready
);

    logic [2:0]         wires_s;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic               frame_commit;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_en, ser_dat, ser_clk}),
        .sync_out (wires_s)
    );

    cfg_frame_rx #(.FRAME_W(FRAME_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (wires_s[0]),
        .sdat_s  (wires_s[1]),
        .sen_s   (wires_s[2]),
        .frame   (frame),
        .bit_cnt (bit_cnt),
        .commit  (frame_commit)
    );

    cfg_reg_file #(.FRAME_W(FRAME_W), .GAIN_MAX(GAIN_MAX)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (frame_commit),
        .frame        (frame),
        .octave_code  (octave_code),
        .freq_step    (freq_step),
        .osc_test     (osc_test),
        .gain_code    (gain_code),
        .gain_half_db (gain_half_db),
        .slot_valid   (slot_valid),
        .cfg_ready    (cfg_ready)
    );

endmodule

// File: rtl/serial_cfg_bank_chk.sv
module serial_cfg_bank_chk #(
    parameter int FRAME_W  = 8,
    parameter int GAIN_MAX = 41,
    localparam int PAY_W   = FRAME_W - 2,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [2:0]       octave_code,
    input logic [6:0]       freq_step,
    input logic             osc_test,
    input logic [PAY_W-1:0] gain_code,
    input logic [PAY_W-1:0] gain_half_db,
    input logic [2:0]       slot_valid,
    input logic             cfg_ready
);

    assert_hold_between_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(octave_code) && $stable(freq_step) && $stable(osc_test)
                     && $stable(gain_code) && $stable(slot_valid)));

    assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_full_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (bit_cnt == CNT_W'(FRAME_W)));

    assert_halfdb_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_half_db <= PAY_W'(GAIN_MAX));

    assert_valid_a_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[0] |=> slot_valid[0]);

    assert_valid_b_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[1] |=> slot_valid[1]);

    assert_valid_g_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[2] |=> slot_valid[2]);

    assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready);

endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(.FRAME_W(FRAME_W), .GAIN_MAX(GAIN_MAX)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (frame_commit),
    .bit_cnt      (bit_cnt),
    .octave_code  (octave_code),
    .freq_step    (freq_step),
    .osc_test     (osc_test),
    .gain_code    (gain_code),
    .gain_half_db (gain_half_db),
    .slot_valid   (slot_valid),
    .cfg_ready    (cfg_ready)
);

// File: tb/test_serial_cfg_bank.sv
`timescale 1ns/1ps
module test_serial_cfg_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_en = 1'b0;
    logic [2:0] octave_code;
    logic [6:0] freq_step;
    logic       osc_test;
    logic [5:0] gain_code;
    logic [5:0] gain_half_db;
    logic [2:0] slot_valid;
    logic       cfg_ready;

    always #4 clk = ~clk;

    serial_cfg_bank i_serial_cfg_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .ser_en       (ser_en),
        .octave_code  (octave_code),
        .freq_step    (freq_step),
        .osc_test     (osc_test),
        .gain_code    (gain_code),
        .gain_half_db (gain_half_db),
        .slot_valid   (slot_valid),
        .cfg_ready    (cfg_ready)
    );

    typedef struct {
        logic [2:0] oct;
        logic [6:0] step;
        logic       osc;
        logic [5:0] gc;
        logic [5:0] hd;
        logic [2:0] vld;
        logic       rdy;
        string      tag;
    } exp_t;

    exp_t  exp_q[$];
    event  item_ev;
    int    n_checks = 0;
    int    n_errors = 0;

    // reference model state
    logic [5:0] m_a, m_g;
    logic [5:0] m_b;
    logic [2:0] m_vld = 3'b000;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic void model_apply(input logic [7:0] f);
        case (f[7:6])
            2'b00: begin m_a = f[5:0]; m_vld[0] = 1'b1; end
            2'b01: begin m_b = f[5:0]; m_vld[1] = 1'b1; end
            2'b11: begin m_g = f[5:0]; m_vld[2] = 1'b1; end
            default: ;
        endcase
    endfunction

    task automatic push_expected(input string tag);
        exp_t e;
        e.oct  = m_a[2:0];
        e.step = {m_b[3:0], m_a[5:3]};
        e.osc  = m_b[5];
        e.gc   = m_g;
        e.hd   = (m_g > 6'd41) ? 6'd41 : m_g;
        e.vld  = m_vld;
        e.rdy  = &m_vld;
        e.tag  = tag;
        exp_q.push_back(e);
        -> item_ev;
    endtask

    // driver: n bits MSB first, half = serial half period in system clocks
    task automatic send_bits(input logic [15:0] bits, input int n, input int half, input string tag);
        @(negedge clk);
        ser_en = 1'b1;
        repeat (2*half) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[n-1-i];
            repeat (half) @(negedge clk);
            ser_clk = 1'b1;
            repeat (half) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (half) @(negedge clk);
        ser_en = 1'b0;
        repeat (12) @(negedge clk);
        if (n >= 8) model_apply(bits[7:0]);
        push_expected(tag);
    endtask

    // monitor
    initial begin
        forever begin
            exp_t e;
            @(item_ev);
            e = exp_q.pop_front();
            check(slot_valid == e.vld, {e.tag, " slot_valid"}, slot_valid, e.vld);
            check(cfg_ready == e.rdy, {e.tag, " cfg_ready (R9)"}, cfg_ready, e.rdy);
            if (e.vld[0])
                check(octave_code == e.oct, {e.tag, " octave_code"}, octave_code, e.oct);
            if (e.vld[0] && e.vld[1])
                check(freq_step == e.step, {e.tag, " freq_step"}, freq_step, e.step);
            if (e.vld[1])
                check(osc_test == e.osc, {e.tag, " osc_test"}, osc_test, e.osc);
            if (e.vld[2]) begin
                check(gain_code == e.gc, {e.tag, " gain_code"}, gain_code, e.gc);
                check(gain_half_db == e.hd, {e.tag, " gain_half_db"}, gain_half_db, e.hd);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(slot_valid == 3'b000, "R9 reset slot_valid", slot_valid, 0);
        check(cfg_ready == 1'b0, "R9 reset cfg_ready", cfg_ready, 0);

        // R1: clock pulses with enable low must not shift or write
        for (int i = 0; i < 8; i++) begin
            ser_dat = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (12) @(negedge clk);
        push_expected("R1 pulses with enable low");

        send_bits(16'h002E, 8, 4, "R4 register A write");
        send_bits(16'h0018, 5, 4, "R3 short frame discarded");
        send_bits(16'h006B, 8, 4, "R5 register B write");
        send_bits(16'h00BF, 8, 4, "R8 address 10 ignored");
        send_bits(16'h00D4, 8, 4, "R6 gain 20 and R9 ready");
        send_bits(16'h00E9, 8, 4, "R6 gain 41");
        send_bits(16'h00FF, 8, 4, "R7 gain 63 clamped");
        send_bits(16'h00EA, 8, 4, "R7 gain 42 clamped");
        send_bits(16'h0319, 10, 4, "R2 long frame keeps last 8");
        send_bits(16'h0007, 8, 2, "R10 fast clock A write");
        send_bits(16'h0000, 8, 2, "R6 R10 clear A");
        send_bits(16'h0040, 8, 2, "R6 R10 clear B");
        send_bits(16'h00C0, 8, 2, "R6 R10 clear gain");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule